// File: doc/BRIEF.md
# Interrupt Event Register Set

This block holds the interrupt state for a peripheral that raises two kinds of event. Bit 0 is "transfer queued" and bit 1 is "transfer completed". Each event pulse is latched into a sticky source register. A mask register decides which latched events may reach the single level interrupt line. A pending view shows the latched events that are currently enabled.

Software reaches all three registers through a plain register port made of an address, write data, a write strobe and registered read data. A mask bit of 1 blocks its interrupt and a mask bit of 0 lets it through. Software acknowledges an event by writing a 1 to its bit in either the source register or the pending register.

The logic that produces the events is outside this block, and so is the logic that turns a system bus into the register port.

Top module: `irq_regs`

## Requirements
- R1: After a synchronous reset, the mask reads all ones in its defined bits (3), the source reads 0, the pending view reads 0, irq is low and read data is 0.
- R2: An event pulse on evt_in bit i (bit 0 = queued, bit 1 = completed) sets source bit i at the next clock edge. The bit stays set when the event repeats, and it falls only when a clear write hits it.
- R3: Events are recorded whatever the mask holds. A masked event still sets its source bit.
- R4: The pending register at offset 0x084 reads source AND NOT mask. Clearing a mask bit over a recorded event makes that event pend straight away.
- R5: irq is a register output. After every clock edge it equals the OR of the pending bits as they stand after that edge.
- R6: Writing to the source register at offset 0x088 clears every source bit where the write data holds a 1. Bits written as 0 keep their value.
- R7: Writing to offset 0x084 clears source bits in the same way as R6, and one write can clear both bits.
- R8: When an event arrives in the same cycle as a clear write to its bit, the bit stays set.
- R9: Writing to offset 0x080 loads the mask from write data bits 1:0. Higher write data bits are ignored, and higher bits of every register read as 0.
- R10: read data shows the addressed register one clock after the address is presented. Any offset other than 0x080, 0x084 and 0x088 reads 0, and writes to such an offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | N_EVT | Event pulses, one bit per interrupt source |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | Level interrupt, high while any pending bit is set |

## Verification
Recording an event and acknowledging it can happen in the same clock cycle. The bench provokes this by raising an event bit during the edge on which a 1 is written to that bit of the source register. After that edge it reads the source back and expects the bit still set. A checker property also requires that every bit pulsed on the event input is set one cycle later, no matter what write happened alongside it. In the same way, a mask write and the irq update share an edge, and the bench samples irq right after the unmasking write.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned OFS_MASK_DEF = 'h080;
  localparam int unsigned OFS_PEND_DEF = 'h084;
  localparam int unsigned OFS_SRC_DEF  = 'h088;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PEND = 2'd2,
    SEL_SRC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_regs_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned OFS_MASK = OFS_MASK_DEF,
  parameter int unsigned OFS_PEND = OFS_PEND_DEF,
  parameter int unsigned OFS_SRC  = OFS_SRC_DEF
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_PEND = AW'(OFS_PEND);
  localparam logic [AW-1:0] A_SRC  = AW'(OFS_SRC);

  always_comb begin
    if (addr == A_MASK)      sel = SEL_MASK;
    else if (addr == A_PEND) sel = SEL_PEND;
    else if (addr == A_SRC)  sel = SEL_SRC;
    else                     sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] src_q,
  output logic [N_EVT-1:0] src_nxt
);
  for (genvar b = 0; b < N_EVT; b++) begin : g_bit
    // a new event outranks an acknowledge in the same cycle
    assign src_nxt[b] = set_i[b] | (src_q[b] & ~clr_i[b]);

    always_ff @(posedge clk) begin
      if (rst) src_q[b] <= 1'b0;
      else     src_q[b] <= src_nxt[b];
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [N_EVT-1:0] wr_val,
  output logic [N_EVT-1:0] mask_q,
  output logic [N_EVT-1:0] mask_nxt
);
  assign mask_nxt = wr_en ? wr_val : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import irq_regs_pkg::*;
#(
  parameter int unsigned N_EVT = 2,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_sel_e         sel,
  input  logic [N_EVT-1:0] mask_q,
  input  logic [N_EVT-1:0] pend,
  input  logic [N_EVT-1:0] src_q,
  output logic [DW-1:0]    rdata
);
  localparam int unsigned PAD = DW - N_EVT;

  logic [N_EVT-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_MASK: pick = mask_q;
      SEL_PEND: pick = pend;
      SEL_SRC:  pick = src_q;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{PAD{1'b0}}, pick};
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned N_EVT    = 2,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 12,
  parameter int unsigned OFS_MASK = OFS_MASK_DEF,
  parameter int unsigned OFS_PEND = OFS_PEND_DEF,
  parameter int unsigned OFS_SRC  = OFS_SRC_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_we,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  reg_sel_e         sel;
  logic [N_EVT-1:0] src_q, src_nxt, mask_q, mask_nxt, pend, w1c;
  logic             mask_wr;

  irq_addr_decode #(
    .AW(AW), .OFS_MASK(OFS_MASK), .OFS_PEND(OFS_PEND), .OFS_SRC(OFS_SRC)
  ) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  assign mask_wr = reg_we && (sel == SEL_MASK);
  assign w1c     = (reg_we && (sel == SEL_SRC || sel == SEL_PEND))
                   ? reg_wdata[N_EVT-1:0] : '0;

  irq_src_bank #(.N_EVT(N_EVT)) u_src (
    .clk     (clk),
    .rst     (rst),
    .set_i   (evt_in),
    .clr_i   (w1c),
    .src_q   (src_q),
    .src_nxt (src_nxt)
  );

  irq_mask_bank #(.N_EVT(N_EVT)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mask_wr),
    .wr_val   (reg_wdata[N_EVT-1:0]),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt)
  );

  assign pend = src_q & ~mask_q;

  irq_rd_port #(.N_EVT(N_EVT), .DW(DW)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .mask_q (mask_q),
    .pend   (pend),
    .src_q  (src_q),
    .rdata  (reg_rdata)
  );

  // irq follows the state that the same edge loads
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(src_nxt & ~mask_nxt);
  end
endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk #(
  parameter int unsigned N_EVT    = 2,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 12,
  parameter int unsigned OFS_MASK = 'h080,
  parameter int unsigned OFS_PEND = 'h084,
  parameter int unsigned OFS_SRC  = 'h088
) (
  input logic             clk,
  input logic             rst,
  input logic [N_EVT-1:0] evt_in,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             reg_we,
  input logic             irq,
  input logic [N_EVT-1:0] src_q,
  input logic [N_EVT-1:0] mask_q
);
  logic [N_EVT-1:0] ack;
  logic             mwr;
  logic             rst_d;

  assign ack = (reg_we && (reg_addr == AW'(OFS_SRC) || reg_addr == AW'(OFS_PEND)))
               ? reg_wdata[N_EVT-1:0] : '0;
  assign mwr = reg_we && (reg_addr == AW'(OFS_MASK));

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d && !rst)
      assert_reset_state_R1: assert (mask_q == '1 && src_q == '0 && !irq)
        else $error("reset state wrong");
  end

  // R2, R8: a pulsed event is always recorded, even against a clear
  assert_evt_recorded_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_in != '0) |=> ((src_q & $past(evt_in)) == $past(evt_in)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(src_q) & ~src_q & ~$past(ack)) == '0));

  // R6 and R7: acknowledged bits with no fresh event fall
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ((ack & ~evt_in) != '0) |=> ((src_q & $past(ack & ~evt_in)) == '0));

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
    irq == |(src_q & ~mask_q));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !mwr |=> $stable(mask_q));
endmodule

bind irq_regs irq_regs_chk #(
  .N_EVT(N_EVT), .DW(DW), .AW(AW),
  .OFS_MASK(OFS_MASK), .OFS_PEND(OFS_PEND), .OFS_SRC(OFS_SRC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_in    (evt_in),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_we    (reg_we),
  .irq       (irq),
  .src_q     (src_q),
  .mask_q    (mask_q)
);

// File: tb/test_irq_regs.sv
`timescale 1ns/1ps
module test_irq_regs;
  localparam int N_EVT = 2;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_MASK = 12'h080;
  localparam logic [AW-1:0] A_PEND = 12'h084;
  localparam logic [AW-1:0] A_SRC  = 12'h088;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_EVT-1:0] evt_in = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_regs i_irq_regs (
    .clk(clk), .rst(rst), .evt_in(evt_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    edge1();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); reg_addr = a;
    edge1();
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [N_EVT-1:0] e);
    @(negedge clk); evt_in = e;
    edge1();
    evt_in = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rdata", reg_rdata, 0);
    rd(A_MASK, v); chk("R1 mask", v, 3);
    rd(A_SRC, v);  chk("R1 src", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
  endtask

  task automatic t_masked_record();
    logic [DW-1:0] v;
    pulse(2'b01);
    chk("R3 irq masked", {31'd0, irq}, 0);
    rd(A_SRC, v);  chk("R3 src masked", v, 1);
    rd(A_PEND, v); chk("R4 pend masked", v, 0);
  endtask

  task automatic t_unmask();
    logic [DW-1:0] v;
    wr(A_MASK, 0);
    chk("R5 irq on unmask", {31'd0, irq}, 1);
    rd(A_PEND, v); chk("R4 pend unmask", v, 1);
    wr(A_MASK, 32'h1);
    chk("R5 irq remask", {31'd0, irq}, 0);
    wr(A_MASK, 0);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] v;
    pulse(2'b01);
    pulse(2'b10);
    rd(A_SRC, v);  chk("R2 sticky src", v, 3);
    wr(A_MASK, 32'h2);
    rd(A_PEND, v); chk("R4 partial mask", v, 1);
    wr(A_MASK, 0);
  endtask

  task automatic t_w1c_src();
    logic [DW-1:0] v;
    wr(A_SRC, 32'h1);
    rd(A_SRC, v); chk("R6 clear bit0", v, 2);
    chk("R5 irq still", {31'd0, irq}, 1);
    wr(A_SRC, 0);
    rd(A_SRC, v); chk("R6 zero write", v, 2);
  endtask

  task automatic t_w1c_pend();
    logic [DW-1:0] v;
    pulse(2'b01);
    wr(A_PEND, 32'h3);
    chk("R7 irq drop", {31'd0, irq}, 0);
    rd(A_SRC, v); chk("R7 both cleared", v, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    @(negedge clk);
    evt_in = 2'b10; reg_addr = A_SRC; reg_wdata = 32'h2; reg_we = 1'b1;
    edge1();
    evt_in = '0; reg_we = 1'b0;
    chk("R8 irq", {31'd0, irq}, 1);
    rd(A_SRC, v); chk("R8 event wins", v, 2);
    wr(A_SRC, 32'h2);
  endtask

  task automatic t_width();
    logic [DW-1:0] v;
    wr(A_MASK, 32'hFFFF_FFFC);
    rd(A_MASK, v); chk("R9 upper ignored", v, 0);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, v); chk("R9 mask full", v, 3);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    pulse(2'b10);
    wr(12'h08C, 32'h3);
    rd(12'h08C, v); chk("R10 unmapped read", v, 0);
    @(negedge clk); reg_addr = A_SRC; #1;
    chk("R10 latency before edge", reg_rdata, 0);
    edge1();
    chk("R10 latency after edge", reg_rdata, 2);
    rd(12'h000, v); chk("R10 zero offset", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset();
    t_masked_record();
    t_unmask();
    t_sticky();
    t_w1c_src();
    t_w1c_pend();
    t_collide();
    t_width();
    t_unmapped();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule